// File: doc/BRIEF.md
# Relocatable RAM Window Decoder

This block decides, for every access on a 16-bit CPU address bus, whether the address hits the on-chip RAM and, if so, which RAM word it refers to. Software places the RAM by writing an 8-bit placement register. The five upper register bits carry address bits 15..11 of the window base. Bit 0 is an alignment flag.

The RAM size is fixed when the block is built: 2, 4, 8, 12 or 16 KB. A window always starts on a multiple of its own size, so the decoder discards the base bits that fall below that boundary. Any value with the right upper bits therefore lands on the same aligned window. A 12 KB array cannot fill a power-of-two slot. It uses the two top register bits to choose a 16 KB slot, and the alignment flag puts it in the upper or the lower 12 KB of that slot. Decoding is purely combinational from the registered placement, so the RAM select and offset follow the address in the same cycle.

Top module: `ram_window_decoder`

## Requirements
- R1: After reset the placement register reads 0x09.
- R2: A register write takes effect at the clock edge where `cfg_we` is high. `cfg_rdata` keeps its old value until that edge and afterwards shows the written byte with bits 2 and 1 forced to zero. Without a write, the register holds its value.
- R3: For the 2, 4, 8 and 16 KB sizes the window starts at {register[7:3], 11 zero bits} with the address bits below the size cleared, and spans exactly the RAM size.
- R4: The low register bits below the size boundary are ignored. The ignored bits are 2..0 for 2 KB, 3..0 for 4 KB, 4..0 for 8 KB and 5..0 for 16 KB. For example, any value from 0x20 through 0x3F gives 0x2000–0x3FFF at 8 KB, and 0x31 does not give 0x3000.
- R5: For 12 KB, register bits 7..6 select a 16 KB slot at register[7:6]×0x4000. With bit 0 = 1 the window is slot+0x1000 to slot+0x3FFF. With bit 0 = 0 it is slot+0x0000 to slot+0x2FFF.
- R6: Bit 0 has no effect on the window for the 2, 4, 8 and 16 KB sizes.
- R7: The value 0x39 ends the window at 0x3FFF in every size: 0x3800, 0x3000, 0x2000, 0x1000 and 0x0000 are the starts for 2, 4, 8, 12 and 16 KB.
- R8: While `ram_sel` is high, `ram_offset` equals the address minus the window start and stays below the RAM size (at most 0x2FFF for 12 KB). While `ram_sel` is low, `ram_offset` is zero.
- R9: `ram_sel` is high exactly for addresses from the window start to the window end and is low for the address just below the start and just above the end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Placement register write strobe |
| cfg_wdata | input | 8 | Placement register write data |
| cfg_rdata | output | 8 | Placement register read-back, bits 2..1 zero |
| addr | input | 16 | CPU address |
| ram_sel | output | 1 | Address falls inside the RAM window |
| ram_offset | output | 14 | RAM-relative byte offset, zero when not selected |

## Verification
The only state in the block is the placement register. A wrong stored bit shows up in two places. It appears on `cfg_rdata` one cycle after the write. It also moves the window at once, so a probe at the start−1, start, end and end+1 addresses of that setting sees `ram_sel` or `ram_offset` change in the same cycle. Sweeping all 256 register values on all five sizes together exposes a mask that keeps or drops the wrong low bits. It also exposes a flag that leaks into a power-of-two size and a 12 KB half chosen the wrong way round, each on the first probe after the offending write.

// File: rtl/ram_window_decoder.sv
module ram_window_decoder #(
  parameter int         RAM_KB    = 8,
  parameter logic [7:0] RESET_VAL = 8'h09
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic [15:0] addr,
  output logic        ram_sel,
  output logic [13:0] ram_offset
);
  localparam int OW    = 14;
  localparam bit SPLIT = (RAM_KB == 12);
  localparam int ALIGN = (RAM_KB == 2) ? 11 : (RAM_KB == 4) ? 12 :
                         (RAM_KB == 8) ? 13 : 14;
  localparam logic [OW-1:0] OFF_MASK = OW'((32'd1 << ALIGN) - 1);

  logic [4:0] base_q;
  logic       high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= RESET_VAL[7:3];
      high_q <= RESET_VAL[0];
    end else if (cfg_we) begin
      base_q <= cfg_wdata[7:3];
      high_q <= cfg_wdata[0];
    end
  end

  logic unused_wdata;
  assign unused_wdata = &{1'b0, cfg_wdata[2:1]};

  assign cfg_rdata = {base_q, 2'b00, high_q};

  generate
    if (SPLIT) begin : g_split
      logic in_slot, in_part;
      assign in_slot    = (addr[15:14] == base_q[4:3]);
      assign in_part    = high_q ? (addr[13:12] != 2'b00) : (addr[13:12] != 2'b11);
      assign ram_sel    = in_slot & in_part;
      assign ram_offset = ram_sel ? (addr[13:0] - (high_q ? 14'h1000 : 14'h0000)) : '0;
    end else begin : g_pow2
      logic [15:0] base_addr;
      assign base_addr  = {base_q, 11'b0};
      assign ram_sel    = (addr[15:ALIGN] == base_addr[15:ALIGN]);
      assign ram_offset = ram_sel ? (addr[OW-1:0] & OFF_MASK) : '0;
    end
  endgenerate
endmodule

// File: rtl/ram_window_decoder_chk.sv
module ram_window_decoder_chk #(
  parameter int RAM_KB = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [15:0] addr,
  input logic        ram_sel,
  input logic [13:0] ram_offset
);
  localparam int SIZE = RAM_KB * 1024;
  logic [15:0] start_addr;
  assign start_addr = addr - {2'b00, ram_offset};

  // R2
  wr_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 8'hF9));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  // R8
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel |-> ram_offset == 14'd0);

  // R8
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> 32'(ram_offset) < SIZE);

  generate
    if (RAM_KB == 12) begin : g_split
      // R5
      slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> start_addr == ({cfg_rdata[7:6], 14'h0} + (cfg_rdata[0] ? 16'h1000 : 16'h0)));
    end else begin : g_pow2
      // R3
      start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel |-> start_addr == ({cfg_rdata[7:3], 11'b0} & ~16'(SIZE - 1)));
    end
  endgenerate
endmodule

bind ram_window_decoder ram_window_decoder_chk #(.RAM_KB(RAM_KB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .addr(addr), .ram_sel(ram_sel), .ram_offset(ram_offset)
);

// File: tb/sim_ram_window_decoder.sv
`timescale 1ns/1ps
module sim_ram_window_decoder;
  localparam int NS = 5;
  localparam int KBS [NS] = '{2, 4, 8, 12, 16};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  rd_v  [NS];
  logic        sel_v [NS];
  logic [13:0] off_v [NS];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NS; g++) begin : gen_sz
    ram_window_decoder #(.RAM_KB(KBS[g])) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(rd_v[g]), .addr(addr), .ram_sel(sel_v[g]), .ram_offset(off_v[g])
    );
  end

  function automatic int win_start(int kb, logic [7:0] v);
    if (kb == 12) return int'(v[7:6]) * 16384 + (v[0] ? 4096 : 0);
    return (int'(v[7:3]) * 2048) / (kb * 1024) * (kb * 1024);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(int a, logic [7:0] v, string req);
    if (a < 0 || a > 65535) return;
    addr = 16'(a);
    #1;
    for (int s = 0; s < NS; s++) begin
      int st = win_start(KBS[s], v);
      int en = st + KBS[s] * 1024 - 1;
      bit es = (a >= st) && (a <= en);
      int eo = es ? a - st : 0;
      chk(sel_v[s] == es, req, $sformatf("sel kb=%0d v=%0h a=%0h", KBS[s], v, a), int'(sel_v[s]), int'(es));
      chk(int'(off_v[s]) == eo, "R8", $sformatf("off kb=%0d v=%0h a=%0h", KBS[s], v, a), int'(off_v[s]), eo);
    end
  endtask

  task automatic t_reset;
    for (int s = 0; s < NS; s++)
      chk(rd_v[s] == 8'h09, "R1", "reset value", int'(rd_v[s]), 9);
    probe(0, 8'h09, "R1");
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'hFF;
    #1;
    chk(rd_v[0] == 8'h09, "R2", "before edge", int'(rd_v[0]), 9);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk(rd_v[0] == 8'hF9, "R2", "after edge masked", int'(rd_v[0]), 'hF9);
    repeat (3) @(negedge clk);
    chk(rd_v[0] == 8'hF9, "R2", "hold without write", int'(rd_v[0]), 'hF9);
  endtask

  task automatic t_magic;
    write_cfg(8'h39);
    addr = 16'h3FFF; #1;
    for (int s = 0; s < NS; s++) begin
      int exp = KBS[s] * 1024 - 1;
      chk(sel_v[s] == 1'b1, "R7", $sformatf("0x39 end hit kb=%0d", KBS[s]), int'(sel_v[s]), 1);
      chk(int'(off_v[s]) == exp, "R7", $sformatf("0x39 end offset kb=%0d", KBS[s]), int'(off_v[s]), exp);
    end
    addr = 16'h4000; #1;
    for (int s = 0; s < NS; s++)
      chk(sel_v[s] == 1'b0, "R7", $sformatf("0x39 past end kb=%0d", KBS[s]), int'(sel_v[s]), 0);
  endtask

  task automatic t_ignored_bits;
    for (int v = 8'h20; v <= 8'h3F; v++) begin
      write_cfg(8'(v));
      addr = 16'h2000; #1;
      chk(sel_v[2] == 1'b1 && off_v[2] == 14'h0, "R4", $sformatf("8KB v=%0h start 0x2000", v), int'(off_v[2]), 0);
      addr = 16'h4000; #1;
      chk(sel_v[2] == 1'b0, "R4", $sformatf("8KB v=%0h not past 0x3FFF", v), int'(sel_v[2]), 0);
    end
  endtask

  task automatic t_flag;
    write_cfg(8'h40);
    addr = 16'h7000; #1;
    chk(sel_v[3] == 1'b0, "R5", "12KB low half excludes top", int'(sel_v[3]), 0);
    addr = 16'h4000; #1;
    chk(sel_v[3] == 1'b1, "R5", "12KB low half base", int'(sel_v[3]), 1);
    chk(sel_v[4] == 1'b1 && off_v[4] == 14'h0, "R6", "16KB flag clear", int'(off_v[4]), 0);
    write_cfg(8'h41);
    addr = 16'h4000; #1;
    chk(sel_v[3] == 1'b0, "R5", "12KB high half excludes bottom", int'(sel_v[3]), 0);
    chk(sel_v[4] == 1'b1 && off_v[4] == 14'h0, "R6", "16KB flag set", int'(off_v[4]), 0);
    addr = 16'h7FFF; #1;
    chk(int'(off_v[3]) == 'h2FFF, "R5", "12KB high half top offset", int'(off_v[3]), 'h2FFF);
  endtask

  task automatic t_sweep;
    for (int v = 0; v < 256; v++) begin
      write_cfg(8'(v));
      for (int s = 0; s < NS; s++)
        chk(rd_v[s] == (8'(v) & 8'hF9), "R2", "readback", int'(rd_v[s]), v & 'hF9);
      for (int s = 0; s < NS; s++) begin
        int st = win_start(KBS[s], 8'(v));
        int en = st + KBS[s] * 1024 - 1;
        probe(st - 1, 8'(v), "R9");
        probe(st, 8'(v), "R3");
        probe(en, 8'(v), "R3");
        probe(en + 1, 8'(v), "R9");
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_write_timing();
    t_magic();
    t_ignored_bits();
    t_flag();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule